// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects the level-sensitive INTA..INTD pins of seven device slots (25 through 31) and folds them onto eight shared interrupt lines, PIRQ A through H. Each shared line then reaches the 24-bit GSI output in two ways. On the interrupt-controller side it always drives its own line, GSI 16+n. On the legacy side, a per-line route byte can steer it onto any one of the GSI lines 0 to 15. Several shared lines may land on the same legacy GSI, and that GSI is then their wired-OR.

The system-control interrupt (SCI) input is merged onto one GSI, chosen by an encoded field in an ACPI control byte. When the selection moves while SCI is active, a small state machine takes the SCI away from the old line for one cycle before raising it on the new one. It has two states. STEADY means SCI drives the current line. HANDOFF means SCI drives no line. There are two transitions: STEADY to HANDOFF on a valid selection change while SCI is high, and HANDOFF to STEADY unconditionally on the next clock. A valid change while SCI is low updates the line directly and stays in STEADY.

Software programs the block through a 4-bit word-addressed register port. Reads are combinational, and writes take effect at the clock edge.

Top module: `pirq_router`

## Requirements
- R1: While reset is held and right after it, gsi_out is all zero. Every route byte reads 0x0080, the ACPI control byte reads 0x0000 (SCI on GSI 9), and each programmable slot map reads its default value.
- R2: Address n (0..7) holds the route byte of PIRQ n. Bits 3:0 are the legacy GSI number and bit 7 is the disable bit. Every legacy GSI 0..15 is the OR of all PIRQs whose disable bit is 0 and whose bits 3:0 equal its number.
- R3: A PIRQ whose route byte has bit 7 set contributes to no legacy GSI, whatever bits 3:0 hold.
- R4: PIRQ n always drives GSI 16+n, independent of the route bytes.
- R5: Out of reset, pin p (0=INTA..3=INTD) of slot s maps to PIRQ ((s+p) mod 4)+4.
- R6: Addresses 9..15 hold the pin maps of slots 25..31, in that order. Pin p selects its PIRQ through bits 4p+2:4p. Bits 3, 7, 11 and 15 read back as zero.
- R7: Slot 30 (address 14) has pins INTA..INTD wired to PIRQ E..H. Its register reads 0 and ignores writes.
- R8: Address 8 is the ACPI control byte, and bits 2:0 select the SCI line. The codes 0, 1, 2, 4 and 5 mean GSI 9, 10, 11, 20 and 21. SCI is ORed onto the selected line, on either the legacy or the APIC side.
- R9: Codes 3, 6 and 7 are reserved. Writing one of them stores the byte but leaves the SCI line unchanged.
- R10: When a valid write moves the selection to another line while SCI is high, the old line loses SCI in the following cycle, and the new line shows SCI one cycle after that. No cycle shows SCI on both lines.
- R11: gsi_out is registered and reflects inputs and register contents one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data at reg_addr |
| slot_int | input | 28 | Slot pins, bit 4k+p is pin p of slot 25+k |
| sci_in | input | 1 | SCI level |
| gsi_out | output | 24 | Registered GSI levels |

## Verification
The bench goes after shared legacy lines. If it kept only one source per line instead of the OR, a line would drop while another PIRQ still holds it. It also checks route bytes with the disable bit set but a valid IRQ number, which would leak onto the legacy side if the bit were ignored.

Writes to slot 30 are checked. A design that stored them would reroute that slot's pins and read back nonzero. Reserved SCI codes are also written, and a naive decoder would move the SCI to some arbitrary line.

The bench moves an active SCI between lines and checks the exact gap cycle. A design without the handoff would show SCI on the new line one cycle early, or on both lines at once.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int PIRQ_N      = 8;
    localparam int LEGACY_N    = 16;
    localparam int GSI_N       = LEGACY_N + PIRQ_N;
    localparam int PINS        = 4;
    localparam int MAP_FW      = 3;
    localparam int MAP_STRIDE  = 4;
    localparam int MAP_REG_W   = PINS * MAP_STRIDE;
    localparam int DATA_W      = 16;
    localparam int ROUTE_W     = 8;
    localparam int ROUTE_DIS   = 7;
    localparam int GSI_IDX_W   = 5;
    localparam int SCI_CODE_W  = 3;
    localparam logic [ROUTE_W-1:0]   ROUTE_RESET   = 8'h80;
    localparam logic [GSI_IDX_W-1:0] SCI_RESET_GSI = 5'd9;

    typedef enum logic [0:0] {
        SCI_STEADY  = 1'b0,
        SCI_HANDOFF = 1'b1
    } sci_state_e;

    typedef struct packed {
        logic                 valid;
        logic [GSI_IDX_W-1:0] gsi;
    } sci_sel_t;

    function automatic sci_sel_t decode_sci(input logic [SCI_CODE_W-1:0] code);
        sci_sel_t r;
        r.valid = 1'b1;
        unique case (code)
            3'd0:    r.gsi = 5'd9;
            3'd1:    r.gsi = 5'd10;
            3'd2:    r.gsi = 5'd11;
            3'd4:    r.gsi = 5'd20;
            3'd5:    r.gsi = 5'd21;
            default: begin
                r.valid = 1'b0;
                r.gsi   = '0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [MAP_REG_W-1:0] map_field_mask();
        logic [MAP_REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < PINS; p++) m[MAP_STRIDE*p +: MAP_FW] = '1;
        return m;
    endfunction

    function automatic logic [MAP_REG_W-1:0] default_map(input int slot);
        logic [MAP_REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < PINS; p++)
            m[MAP_STRIDE*p +: MAP_FW] = MAP_FW'(((slot + p) % 4) + 4);
        return m;
    endfunction

    function automatic logic [MAP_REG_W-1:0] bridge_map();
        logic [MAP_REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < PINS; p++) m[MAP_STRIDE*p +: MAP_FW] = MAP_FW'(p + 4);
        return m;
    endfunction
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int NUM_SLOTS  = 7,
    parameter int FIRST_SLOT = 25,
    parameter int FIXED_SLOT = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [ROUTE_W-1:0]   route_q [PIRQ_N],
    output logic [7:0]           acpi_q,
    output logic [MAP_REG_W-1:0] eff_map [NUM_SLOTS]
);
    localparam int ACPI_ADDR = PIRQ_N;
    localparam int MAP_BASE  = PIRQ_N + 1;
    localparam logic [MAP_REG_W-1:0] MAP_MASK = map_field_mask();

    logic [MAP_REG_W-1:0] map_rd [NUM_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < PIRQ_N; n++) route_q[n] <= ROUTE_RESET;
            acpi_q <= '0;
        end else if (we) begin
            for (int n = 0; n < PIRQ_N; n++)
                if (addr == ADDR_W'(n)) route_q[n] <= wdata[ROUTE_W-1:0];
            if (addr == ADDR_W'(ACPI_ADDR)) acpi_q <= wdata[7:0];
        end
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam int SLOT = FIRST_SLOT + k;
        if (SLOT == FIXED_SLOT) begin : g_fixed
            assign eff_map[k] = bridge_map();
            assign map_rd[k]  = '0;
        end else begin : g_prog
            logic [MAP_REG_W-1:0] map_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    map_q <= default_map(SLOT);
                else if (we && addr == ADDR_W'(MAP_BASE + k))
                    map_q <= wdata & MAP_MASK;
            end
            assign eff_map[k] = map_q;
            assign map_rd[k]  = map_q;
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < PIRQ_N; n++)
            if (addr == ADDR_W'(n)) rdata = {{(DATA_W-ROUTE_W){1'b0}}, route_q[n]};
        if (addr == ADDR_W'(ACPI_ADDR)) rdata = {8'h00, acpi_q};
        for (int k = 0; k < NUM_SLOTS; k++)
            if (addr == ADDR_W'(MAP_BASE + k)) rdata = map_rd[k];
    end
endmodule

// File: rtl/pirq_pin_mapper.sv
module pirq_pin_mapper
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input  logic [NUM_SLOTS*PINS-1:0] slot_int,
    input  logic [MAP_REG_W-1:0]      eff_map [NUM_SLOTS],
    output logic [PIRQ_N-1:0]         pirq_lvl
);
    always_comb begin
        pirq_lvl = '0;
        for (int k = 0; k < NUM_SLOTS; k++)
            for (int p = 0; p < PINS; p++)
                if (slot_int[k*PINS + p])
                    pirq_lvl[eff_map[k][MAP_STRIDE*p +: MAP_FW]] = 1'b1;
    end
endmodule

// File: rtl/sci_steer.sv
module sci_steer
    import pirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_we,
    input  logic [SCI_CODE_W-1:0] sel_code,
    input  logic                  sci_in,
    output logic [GSI_N-1:0]      sci_vec,
    output sci_state_e            state_q,
    output logic [GSI_IDX_W-1:0]  cur_q
);
    sci_state_e           state_d;
    logic [GSI_IDX_W-1:0] cur_d, pend_q, pend_d;
    sci_sel_t             dec;

    always_comb begin
        dec     = decode_sci(sel_code);
        state_d = state_q;
        cur_d   = cur_q;
        pend_d  = pend_q;
        unique case (state_q)
            SCI_STEADY: begin
                if (sel_we && dec.valid && dec.gsi != cur_q) begin
                    if (sci_in) begin
                        state_d = SCI_HANDOFF;
                        pend_d  = dec.gsi;
                    end else begin
                        cur_d = dec.gsi;
                    end
                end
            end
            SCI_HANDOFF: begin
                state_d = SCI_STEADY;
                cur_d   = (sel_we && dec.valid) ? dec.gsi : pend_q;
            end
            default: state_d = SCI_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCI_STEADY;
            cur_q   <= SCI_RESET_GSI;
            pend_q  <= SCI_RESET_GSI;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        sci_vec = '0;
        unique case (state_q)
            SCI_STEADY:  if (sci_in) sci_vec[cur_q] = 1'b1;
            SCI_HANDOFF: sci_vec = '0;
            default:     sci_vec = '0;
        endcase
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int NUM_SLOTS  = 7,
    parameter int FIRST_SLOT = 25,
    parameter int FIXED_SLOT = 30
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic [NUM_SLOTS*PINS-1:0] slot_int,
    input  logic                      sci_in,
    output logic [GSI_N-1:0]          gsi_out
);
    localparam int ACPI_ADDR  = PIRQ_N;
    localparam int FIXED_ADDR = PIRQ_N + 1 + (FIXED_SLOT - FIRST_SLOT);

    logic [ROUTE_W-1:0]   route_q [PIRQ_N];
    logic [7:0]           acpi_q;
    logic [MAP_REG_W-1:0] eff_map [NUM_SLOTS];
    logic [PIRQ_N-1:0]    pirq_lvl;
    logic [GSI_N-1:0]     sci_vec, gsi_d;
    sci_state_e           steer_state;
    logic [GSI_IDX_W-1:0] cur_gsi;
    logic                 sel_we;

    assign sel_we = reg_we && (reg_addr == ADDR_W'(ACPI_ADDR));

    pirq_regs #(
        .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS),
        .FIRST_SLOT(FIRST_SLOT), .FIXED_SLOT(FIXED_SLOT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .route_q(route_q), .acpi_q(acpi_q), .eff_map(eff_map)
    );

    pirq_pin_mapper #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .slot_int(slot_int), .eff_map(eff_map), .pirq_lvl(pirq_lvl)
    );

    sci_steer u_sci (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we),
        .sel_code(reg_wdata[SCI_CODE_W-1:0]), .sci_in(sci_in),
        .sci_vec(sci_vec), .state_q(steer_state), .cur_q(cur_gsi)
    );

    always_comb begin
        gsi_d = sci_vec;
        for (int n = 0; n < PIRQ_N; n++) begin
            if (pirq_lvl[n]) begin
                gsi_d[LEGACY_N + n] = 1'b1;
                if (!route_q[n][ROUTE_DIS]) gsi_d[route_q[n][3:0]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gsi_out <= '0;
        else        gsi_out <= gsi_d;
    end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIXED_ADDR = 14
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [PIRQ_N-1:0]     pirq_lvl,
    input logic [GSI_N-1:0]      gsi_out,
    input logic [GSI_N-1:0]      sci_vec,
    input sci_state_e            steer_state,
    input logic                  sel_we,
    input logic [SCI_CODE_W-1:0] sel_code,
    input logic [GSI_IDX_W-1:0]  cur_gsi,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic [DATA_W-1:0]     reg_rdata
);
    for (genvar n = 0; n < PIRQ_N; n++) begin : g_apic
        AST_APIC_FOLLOWS_PIRQ: assert property (@(posedge clk) disable iff (!rst_n)
            pirq_lvl[n] |=> gsi_out[LEGACY_N + n]); // R4
    end

    AST_SCI_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sci_vec)); // R8

    AST_HANDOFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_state == SCI_HANDOFF) |=> (steer_state == SCI_STEADY)); // R10

    AST_HANDOFF_NO_SCI: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_state == SCI_HANDOFF) |-> (sci_vec == '0)); // R10

    AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_state == SCI_STEADY && sel_we && !decode_sci(sel_code).valid)
        |=> $stable(cur_gsi)); // R9

    AST_BRIDGE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(FIXED_ADDR)) |-> (reg_rdata == '0)); // R7
endmodule

bind pirq_router pirq_router_chk #(
    .ADDR_W(ADDR_W), .FIXED_ADDR(FIXED_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .gsi_out(gsi_out),
    .sci_vec(sci_vec), .steer_state(steer_state), .sel_we(sel_we),
    .sel_code(reg_wdata[2:0]), .cur_gsi(cur_gsi),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 7;
    localparam int FIXED_IDX = 5;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic [27:0] slot_int = 0;
    logic        sci_in = 0;
    logic [23:0] gsi_out;

    pirq_router dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_route [8];
    int m_acpi;
    int m_map [NSLOT];
    int m_cur, m_pend, m_gap;
    logic [23:0] m_exp;

    function automatic int sci_line(int code);
        case (code)
            0: return 9;
            1: return 10;
            2: return 11;
            4: return 20;
            5: return 21;
            default: return -1;
        endcase
    endfunction

    function automatic int pirq_of(int k, int p);
        if (k == FIXED_IDX) return p + 4;
        return (m_map[k] >> (4*p)) & 7;
    endfunction

    function automatic int model_read(int a);
        if (a < 8) return m_route[a];
        if (a == 8) return m_acpi;
        return m_map[a-9];
    endfunction

    task automatic model_reset();
        for (int n = 0; n < 8; n++) m_route[n] = 'h80;
        m_acpi = 0;
        for (int k = 0; k < NSLOT; k++) begin
            m_map[k] = 0;
            if (k != FIXED_IDX)
                for (int p = 0; p < 4; p++) m_map[k] |= (((25+k+p) % 4) + 4) << (4*p);
        end
        m_cur = 9; m_pend = 9; m_gap = 0; m_exp = '0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else begin
            logic [7:0] pl;
            logic [23:0] e;
            int sl;
            pl = '0;
            for (int k = 0; k < NSLOT; k++)
                for (int p = 0; p < 4; p++)
                    if (slot_int[4*k+p]) pl[pirq_of(k,p)] = 1;
            e = '0;
            for (int n = 0; n < 8; n++)
                if (pl[n]) begin
                    e[16+n] = 1;
                    if ((m_route[n] & 'h80) == 0) e[m_route[n] & 15] = 1;
                end
            if (m_gap == 0 && sci_in) e[m_cur] = 1;
            m_exp = e;
            sl = (reg_we && reg_addr == 8) ? sci_line(reg_wdata & 7) : -1;
            if (m_gap == 1) begin
                m_gap = 0;
                m_cur = (sl >= 0) ? sl : m_pend;
            end else if (sl >= 0 && sl != m_cur) begin
                if (sci_in) begin m_gap = 1; m_pend = sl; end
                else m_cur = sl;
            end
            if (reg_we) begin
                if (reg_addr < 8) m_route[reg_addr] = reg_wdata & 'hFF;
                else if (reg_addr == 8) m_acpi = reg_wdata & 'hFF;
                else if (reg_addr - 9 != FIXED_IDX) m_map[reg_addr-9] = reg_wdata & 'h7777;
            end
        end
    end

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (gsi_out !== m_exp) begin
                fails++;
                $display("FAIL %s cycle compare: gsi_out=%h expected=%h", cur_req, gsi_out, m_exp);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_we = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(string req, int a);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 chk(req, 32'(reg_rdata), 32'(model_read(a)));
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        wait_cyc(3);
        chk("R1 gsi in reset", 32'(gsi_out), 32'h0);
        rst_n = 1;
        wait_cyc(2);
        chk("R1 gsi after reset", 32'(gsi_out), 32'h0);
        for (int a = 0; a < 16; a++) rd("R1 reset readback", a);

        // R5 default map, one pin at a time (routes disabled, APIC side only)
        cur_req = "R5";
        for (int k = 0; k < NSLOT; k++)
            for (int p = 0; p < 4; p++) begin
                @(negedge clk); slot_int = 28'(1) << (4*k+p);
                wait_cyc(2);
                if (k != FIXED_IDX)
                    chk("R5 default pin map", 32'(gsi_out), 32'(24'(1) << (16 + ((25+k+p)%4)+4)));
                slot_int = 0;
            end

        // R7 bridge slot: writes ignored, reads zero, pins go to E..H
        cur_req = "R7";
        wr(14, 'hFFFF);
        rd("R7 bridge reads zero", 14);
        chk("R7 bridge raw read", 32'(reg_rdata), 32'h0);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); slot_int = 28'(1) << (4*FIXED_IDX+p);
            wait_cyc(2);
            chk("R7 bridge pin to E..H", 32'(gsi_out), 32'(24'(1) << (20+p)));
            slot_int = 0;
        end

        // R2 / R3 legacy routing, shared lines and disable bit
        cur_req = "R2";
        wr(0, 5); wr(1, 5); wr(2, 12); wr(3, 'h85);
        for (int a = 0; a < 4; a++) rd("R2 route readback", a);
        // slot 27 (k=2): pin p -> PIRQ ((27+p)%4)+4 ; use programmed maps instead
        wr(9, 'h3210);      // slot 25: INTA..INTD -> A,B,C,D
        rd("R6 map readback", 9);
        @(negedge clk); slot_int = 28'h3; // A and B both on legacy 5
        wait_cyc(2);
        chk("R2 shared legacy line", 32'(gsi_out), 32'h030020);
        @(negedge clk); slot_int = 28'h2; // only B
        wait_cyc(2);
        chk("R2 line held by other source", 32'(gsi_out), 32'h020020);
        cur_req = "R3";
        @(negedge clk); slot_int = 28'h8; // D disabled with irq 5
        wait_cyc(2);
        chk("R3 disabled route quiet", 32'(gsi_out), 32'h080000);
        @(negedge clk); slot_int = 28'h4; // C -> 12
        wait_cyc(2);
        chk("R2 route to 12", 32'(gsi_out), 32'h041000);
        slot_int = 0;

        // R6 field positions and unused bits
        cur_req = "R6";
        wr(10, 'hFFFF);
        rd("R6 unused bits zero", 10);
        chk("R6 masked value", 32'(reg_rdata), 32'h7777);
        wr(10, 'h0527);
        @(negedge clk); slot_int = 28'h20;   // slot 26 pin1 -> field bits 6:4 = 2
        wait_cyc(2);
        chk("R6 pin1 field", 32'(gsi_out), 32'h041000);
        slot_int = 0;

        // R8 SCI decode for each code
        cur_req = "R8";
        @(negedge clk); sci_in = 1;
        for (int c = 0; c < 8; c++) begin
            wr(8, c);
            wait_cyc(3);
            rd("R8 acpi readback", 8);
        end
        wr(8, 1);
        wait_cyc(3);
        chk("R8 sci on gsi 10", 32'(gsi_out), 32'h000400);

        // R9 reserved code keeps line
        cur_req = "R9";
        wr(8, 6);
        wait_cyc(3);
        chk("R9 reserved keeps gsi 10", 32'(gsi_out), 32'h000400);

        // R10 handoff 10 -> 20 with one empty cycle
        cur_req = "R10";
        @(negedge clk);
        reg_we = 1; reg_addr = 8; reg_wdata = 4;
        @(negedge clk);
        reg_we = 0;
        #1 chk("R10 old line before gap", 32'(gsi_out), 32'h000400);
        @(negedge clk);
        #1 chk("R10 gap cycle", 32'(gsi_out), 32'h0);
        @(negedge clk);
        #1 chk("R10 new line", 32'(gsi_out), 32'h100000);
        // back-to-back write during the gap
        @(negedge clk);
        reg_we = 1; reg_addr = 8; reg_wdata = 0;
        @(negedge clk);
        reg_wdata = 2;
        @(negedge clk);
        reg_we = 0;
        wait_cyc(3);
        chk("R10 write in gap wins", 32'(gsi_out), 32'h000800);
        sci_in = 0;
        wr(8, 5);
        @(negedge clk); sci_in = 1;
        wait_cyc(2);
        chk("R8 idle change direct", 32'(gsi_out), 32'h200000);

        // R11 mixed random traffic against the cycle model
        cur_req = "R11";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            slot_int = 28'($urandom) & 28'($urandom) & 28'($urandom);
            if (($urandom % 8) == 0) sci_in = ~sci_in;
            reg_we = (($urandom % 6) == 0);
            reg_addr = 4'($urandom);
            reg_wdata = 16'($urandom);
        end
        @(negedge clk); reg_we = 0; slot_int = 0;
        for (int a = 0; a < 16; a++) rd("R11 final readback", a);
        wait_cyc(2);
        finish_run();
    end
endmodule